// File: doc/BRIEF.md
# Auto-Baud Serial Byte Receiver

This receiver takes bytes from a single-wire asynchronous serial line whose bit rate is not known in advance. Each byte is a low start bit, eight data bits sent least significant first, and a high stop bit, with no parity. Every frame opens with the pattern 0x55. The receiver times that pattern against its own clock to learn the bit period, then samples the following bytes at the middle of each bit. Because the rate is re-learned at the start of each frame, the local clock only has to be stable, not accurate.

The measured period is published on a port so that a transmitter on the same wire can answer at the same rate. The controlling logic raises `expect_sync` when the next byte is a frame opener, which lets the rate change between frames. If the line stays still for longer than a programmable number of clocks while a frame is open, the receiver drops the frame, pulses a timeout flag and goes back to hunting for a new sync pattern. A stop bit that reads low, or a sync pattern whose period falls outside the legal range, also returns the receiver to hunting.

Top module: `abr_rx`

## Requirements
- R1: After reset, `rx_valid`, `locked` and `timeout_pulse` are low and `bit_period` is zero.
- R2: A 0x55 byte received while hunting (or while locked with `expect_sync` high) sets `bit_period` to the clock count from its first falling edge to its fifth falling edge, divided by eight and rounded down, and sets `locked` once its stop bit is read high. Periods equal to `MIN_PERIOD` and to `MAX_PERIOD` are accepted.
- R3: A sync pattern whose measured period is below `MIN_PERIOD` or above `MAX_PERIOD` leaves `bit_period` unchanged and leaves `locked` low (a failed re-sync clears it).
- R4: While locked with `expect_sync` low, each byte is delivered on `rx_data` with a one-cycle `rx_valid`; bit 0 of `rx_data` is the first data bit after the start bit. Sync bytes are never delivered.
- R5: `rx_valid` rises 9.5 bit periods plus three clocks (plus or minus two) after the start bit's falling edge on the pin.
- R6: A data byte whose stop bit reads low is not delivered and clears `locked`.
- R7: With `expect_sync` high while locked, the next byte is measured as a new sync pattern, so the bit rate may change between frames without an intervening timeout.
- R8: When the line shows no transition for `timeout_cycles` clocks while a frame is open, `timeout_pulse` is high for exactly one cycle and `locked` clears; bytes sent afterwards without a sync pattern are not delivered.
- R9: A `timeout_cycles` value of zero disables the timeout: `locked` holds and no pulse occurs however long the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Serial line, idle high, asynchronous to `clk` |
| timeout_cycles | input | TO_W | Idle clocks that abandon an open frame; zero disables |
| expect_sync | input | 1 | High when the next byte opens a frame with a sync pattern |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |
| bit_period | output | PER_W | Learned bit period in clocks |
| locked | output | 1 | A legal bit period is held and data bytes are accepted |
| timeout_pulse | output | 1 | One-cycle strobe when an open frame is dropped for silence |

## Verification
A delivered byte is due 9.5 bit periods plus three clocks after its start edge reaches the pin: two synchronizer stages, one state register, then the bit timer and the output register. The driver stamps the clock count when it pulls the line low and queues the expected byte with that stamp; the monitor, sampling on the falling clock edge, pops an entry on every strobe and checks both the value and the delay against a window of two clocks either side. Lock state, the period and timeout counts are read only after the stop bit of the byte concerned and one further idle bit, when every register involved has settled.

// File: rtl/abr_pkg.sv
package abr_pkg;

    // Falling edges of 0x55 after the first one: the fifth edge closes 8 bit periods.
    localparam int unsigned SYNC_EXTRA_FALLS = 4;
    localparam int unsigned DATA_BITS        = 8;

    typedef enum logic [2:0] {
        S_HUNT      = 3'd0,  // no rate known, wait for a sync start edge
        S_MEAS      = 3'd1,  // counting clocks across the sync pattern
        S_SYNC_STOP = 3'd2,  // wait for mid stop bit of the sync byte
        S_IDLE      = 3'd3,  // locked, wait for a start edge
        S_DATA      = 3'd4,  // sampling data bits at mid-bit
        S_STOP      = 3'd5   // sampling the stop bit of a data byte
    } rx_state_e;

    function automatic logic period_ok(input int unsigned p,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (p >= lo) && (p <= hi);
    endfunction

endpackage

// File: rtl/abr_line_sync.sv
module abr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic line,
    output logic fall,
    output logic toggle
);
    // chain[STAGES-1] is the synchronized line, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    assign line   = chain[STAGES-1];
    assign fall   = chain[STAGES] & ~chain[STAGES-1];
    assign toggle = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/abr_idle_timer.sv
module abr_idle_timer #(
    parameter int TO_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            toggle,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst)                quiet <= '0;
        else if (toggle)        quiet <= '0;
        else if (quiet != '1)   quiet <= quiet + 1'b1;
    end

    assign expired = (limit != '0) && (quiet == limit);

endmodule

// File: rtl/abr_bit_timer.sv
module abr_bit_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;
    logic         armed;

    // done is high exactly load_val clocks after the load cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= (load_val == '0) ? '0 : load_val - 1'b1;
            armed <= 1'b1;
        end else if (armed) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else           armed <= 1'b0;
        end
    end

    assign done = armed && (cnt == '0);

endmodule

// File: rtl/abr_rx_fsm.sv
module abr_rx_fsm
    import abr_pkg::*;
#(
    parameter int MIN_PERIOD = 50,
    parameter int MAX_PERIOD = 5000,
    parameter int PER_W      = 13,
    parameter int TW         = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic             fall,
    input  logic             expired,
    input  logic             expect_sync,
    input  logic             tdone,
    output logic             t_load,
    output logic [TW-1:0]    t_val,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic [PER_W-1:0] bit_period,
    output logic             locked,
    output logic             timeout_pulse
);
    localparam int MW = PER_W + 4;           // holds 8*MAX_PERIOD with margin
    localparam int CW = MW - 3;              // candidate period width

    rx_state_e        state;
    logic [MW-1:0]    meas_cnt;
    logic [1:0]       edge_n;
    logic [CW-1:0]    cand, cand_q;
    logic [2:0]       bit_idx;
    logic [7:0]       sh;
    logic             drop;
    logic             last_fall;

    assign cand      = meas_cnt[MW-1:3];
    assign drop      = expired && (state != S_HUNT);
    assign last_fall = fall && (edge_n == 2'(SYNC_EXTRA_FALLS - 1));

    // timer reload requests: 1.5 periods to the first sample, then 1 period
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (!drop) begin
            case (state)
                S_MEAS: if (last_fall) begin
                    t_load = 1'b1;
                    t_val  = TW'(cand) + TW'(cand >> 1);
                end
                S_IDLE: if (fall && !expect_sync) begin
                    t_load = 1'b1;
                    t_val  = TW'(bit_period) + TW'(bit_period >> 1);
                end
                S_DATA: if (tdone) begin
                    t_load = 1'b1;
                    t_val  = TW'(bit_period);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_HUNT;
            meas_cnt      <= '0;
            edge_n        <= '0;
            cand_q        <= '0;
            bit_idx       <= '0;
            sh            <= '0;
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            bit_period    <= '0;
            locked        <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            rx_valid      <= 1'b0;
            timeout_pulse <= 1'b0;
            if (meas_cnt != '1) meas_cnt <= meas_cnt + 1'b1;

            if (drop) begin
                state         <= S_HUNT;
                locked        <= 1'b0;
                timeout_pulse <= 1'b1;
            end else begin
                case (state)
                    S_HUNT: if (fall) begin
                        state    <= S_MEAS;
                        meas_cnt <= MW'(1);
                        edge_n   <= '0;
                    end
                    S_MEAS: if (fall) begin
                        if (last_fall) begin
                            cand_q <= cand;
                            state  <= S_SYNC_STOP;
                        end else begin
                            edge_n <= edge_n + 1'b1;
                        end
                    end
                    S_SYNC_STOP: if (tdone) begin
                        if (line && period_ok(32'(cand_q), MIN_PERIOD, MAX_PERIOD)) begin
                            locked     <= 1'b1;
                            bit_period <= PER_W'(cand_q);
                            state      <= S_IDLE;
                        end else begin
                            locked <= 1'b0;
                            state  <= S_HUNT;
                        end
                    end
                    S_IDLE: if (fall) begin
                        if (expect_sync) begin
                            state    <= S_MEAS;
                            meas_cnt <= MW'(1);
                            edge_n   <= '0;
                        end else begin
                            state   <= S_DATA;
                            bit_idx <= '0;
                        end
                    end
                    S_DATA: if (tdone) begin
                        sh <= {line, sh[7:1]};
                        if (bit_idx == 3'(DATA_BITS - 1)) state <= S_STOP;
                        else                             bit_idx <= bit_idx + 1'b1;
                    end
                    S_STOP: if (tdone) begin
                        if (line) begin
                            rx_data  <= sh;
                            rx_valid <= 1'b1;
                            state    <= S_IDLE;
                        end else begin
                            locked <= 1'b0;
                            state  <= S_HUNT;
                        end
                    end
                    default: state <= S_HUNT;
                endcase
            end
        end
    end

    // R4: a byte strobe never lasts two cycles
    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6: bytes are only delivered while a rate is held
    a_r6_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> locked);

    // R2/R3: a held rate always lies in the legal window
    a_r3_locked_legal: assert property (@(posedge clk) disable iff (rst)
        locked |-> period_ok(32'(bit_period), MIN_PERIOD, MAX_PERIOD));

    // R8: a timeout pulse is one cycle long and leaves the receiver unlocked
    a_r8_tmo_single: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse);

    a_r8_tmo_unlocks: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> !locked);

    // R2: the period only changes when a lock is (re)acquired
    a_r2_period_on_lock: assert property (@(posedge clk) disable iff (rst)
        !$stable(bit_period) |-> locked);

endmodule

// File: rtl/abr_rx.sv
module abr_rx #(
    parameter int MIN_PERIOD  = 50,
    parameter int MAX_PERIOD  = 5000,
    parameter int TO_W        = 20,
    parameter int SYNC_STAGES = 2,
    localparam int PER_W      = $clog2(MAX_PERIOD + 1),
    localparam int TW         = PER_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_pin,
    input  logic [TO_W-1:0]  timeout_cycles,
    input  logic             expect_sync,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic [PER_W-1:0] bit_period,
    output logic             locked,
    output logic             timeout_pulse
);
    logic          line, fall, toggle, expired, tdone, t_load;
    logic [TW-1:0] t_val;

    abr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(rx_pin),
        .line(line), .fall(fall), .toggle(toggle)
    );

    abr_idle_timer #(.TO_W(TO_W)) u_idle (
        .clk(clk), .rst(rst), .toggle(toggle),
        .limit(timeout_cycles), .expired(expired)
    );

    abr_bit_timer #(.W(TW)) u_btim (
        .clk(clk), .rst(rst), .load(t_load),
        .load_val(t_val), .done(tdone)
    );

    abr_rx_fsm #(
        .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
        .PER_W(PER_W), .TW(TW)
    ) u_fsm (
        .clk(clk), .rst(rst), .line(line), .fall(fall),
        .expired(expired), .expect_sync(expect_sync), .tdone(tdone),
        .t_load(t_load), .t_val(t_val),
        .rx_data(rx_data), .rx_valid(rx_valid), .bit_period(bit_period),
        .locked(locked), .timeout_pulse(timeout_pulse)
    );

endmodule

// File: tb/abr_rx_bench.sv
module abr_rx_bench;
    localparam int MINP = 8;
    localparam int MAXP = 400;
    localparam int TOW  = 16;
    localparam int PW   = $clog2(MAXP + 1);

    typedef struct {
        logic [7:0] data;
        int         t0;
        int         per;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rx_pin = 1'b1;
    logic [TOW-1:0] tmo = '0;
    logic           expect_sync = 1'b0;
    logic [7:0]     rx_data;
    logic           rx_valid;
    logic [PW-1:0]  bit_period;
    logic           locked;
    logic           timeout_pulse;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   tmo_seen = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    abr_rx #(.MIN_PERIOD(MINP), .MAX_PERIOD(MAXP), .TO_W(TOW)) u_abr_rx (
        .clk(clk), .rst(rst), .rx_pin(rx_pin), .timeout_cycles(tmo),
        .expect_sync(expect_sync), .rx_data(rx_data), .rx_valid(rx_valid),
        .bit_period(bit_period), .locked(locked), .timeout_pulse(timeout_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int per);
        rx_pin = v;
        repeat (per) @(negedge clk);
    endtask

    // send one byte; push an expected entry when delivery is due
    task automatic send_byte(input logic [7:0] b, input int per,
                             input bit deliver, input logic stop_v);
        exp_t e;
        @(negedge clk);
        e.data = b; e.t0 = cyc; e.per = per;
        if (deliver) q.push_back(e);
        drive_bit(1'b0, per);
        for (int i = 0; i < 8; i++) drive_bit(b[i], per);
        drive_bit(stop_v, per);
        if (!stop_v) drive_bit(1'b1, per);
    endtask

    task automatic idle(input int n);
        rx_pin = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && timeout_pulse) tmo_seen++;
        if (!rst && rx_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4 unexpected byte", int'(rx_data), -1);
            end else begin
                exp_t e;
                int   due;
                e   = q.pop_front();
                due = (19 * e.per) / 2 + 3;
                chk(rx_data == e.data, "R4 data", int'(rx_data), int'(e.data));
                chk((cyc - e.t0 >= due - 2) && (cyc - e.t0 <= due + 2),
                    "R5 delay", cyc - e.t0, due);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        tmo = TOW'(320);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!rx_valid, "R1 rx_valid", int'(rx_valid), 0);
        chk(!locked, "R1 locked", int'(locked), 0);
        chk(!timeout_pulse, "R1 timeout_pulse", int'(timeout_pulse), 0);
        chk(bit_period == '0, "R1 bit_period", int'(bit_period), 0);

        // R2 lock at 16 clocks per bit, R4/R5 data bytes
        send_byte(8'h55, 16, 0, 1'b1); idle(16);
        chk(locked, "R2 locked", int'(locked), 1);
        chk(bit_period == 16, "R2 bit_period", int'(bit_period), 16);
        send_byte(8'hA3, 16, 1, 1'b1); idle(16);
        send_byte(8'h00, 16, 1, 1'b1); idle(16);
        send_byte(8'hFF, 16, 1, 1'b1);
        // R8 idle after the frame drops it
        idle(400);
        chk(tmo_seen == 1, "R8 pulse count", tmo_seen, 1);
        chk(!locked, "R8 unlocked", int'(locked), 0);

        // R8 byte without sync after a timeout is not delivered
        send_byte(8'h55, 16, 0, 1'b1); idle(400);
        chk(tmo_seen == 2, "R8 pulse count", tmo_seen, 2);
        send_byte(8'hA5, 16, 0, 1'b1); idle(400);
        chk(tmo_seen == 3, "R8 pulse count", tmo_seen, 3);
        chk(!locked, "R8 still unlocked", int'(locked), 0);

        // R7 rate change inside a frame
        tmo = TOW'(800);
        send_byte(8'h55, 40, 0, 1'b1); idle(40);
        chk(bit_period == 40, "R2 bit_period", int'(bit_period), 40);
        send_byte(8'h3C, 40, 1, 1'b1); idle(40);
        expect_sync = 1'b1;
        send_byte(8'h55, 24, 0, 1'b1);
        expect_sync = 1'b0;
        idle(24);
        chk(locked, "R7 locked", int'(locked), 1);
        chk(bit_period == 24, "R7 bit_period", int'(bit_period), 24);
        send_byte(8'hC5, 24, 1, 1'b1); idle(24);

        // R6 low stop bit
        send_byte(8'h96, 24, 0, 1'b0); idle(24);
        chk(!locked, "R6 unlocked", int'(locked), 0);

        // R3 period below range
        send_byte(8'h55, 7, 0, 1'b1); idle(14);
        chk(!locked, "R3 short rejected", int'(locked), 0);
        chk(bit_period == 24, "R3 period kept", int'(bit_period), 24);

        // R9 disabled timeout; R2 lower boundary
        tmo = '0;
        send_byte(8'h55, 8, 0, 1'b1); idle(8);
        chk(bit_period == 8, "R2 min boundary", int'(bit_period), 8);
        idle(3000);
        chk(locked, "R9 lock held", int'(locked), 1);
        chk(tmo_seen == 3, "R9 no pulse", tmo_seen, 3);
        send_byte(8'h81, 8, 1, 1'b1); idle(8);

        // R3 failed re-sync above range clears lock
        tmo = TOW'(8020);
        expect_sync = 1'b1;
        send_byte(8'h55, 401, 0, 1'b1);
        expect_sync = 1'b0;
        idle(20);
        chk(!locked, "R3 long rejected", int'(locked), 0);
        chk(bit_period == 8, "R3 period kept", int'(bit_period), 8);

        // R2 upper boundary
        send_byte(8'h55, 400, 0, 1'b1); idle(400);
        chk(locked, "R2 max locked", int'(locked), 1);
        chk(bit_period == 400, "R2 max boundary", int'(bit_period), 400);
        send_byte(8'h5A, 400, 1, 1'b1); idle(20);

        chk(q.size() == 0, "R4 pending bytes", q.size(), 0);
        finish_run();
    end

endmodule